// File: doc/BRIEF.md
# Generalized Bit Permutation Unit (reverse, OR-combine, shuffle)

This block computes one of four bit permutations of a 64-bit operand with a single combinational path. The result of an operation is always a function of the data operand and a small control amount taken from the low bits of a second operand. There are six stage positions, one for each power-of-two distance from 1 to 32. Each stage makes a single decision for the whole word: either every bit pair at that distance moves, or none does.

Two of the operations run the six stages of a butterfly chain in order of increasing distance. Generalized reverse replaces the word with its swapped version at each enabled stage. Generalized OR-combine merges the swapped version into the word instead. Shuffle and unshuffle use five interleave stages. Shuffle walks from the widest distance down, and unshuffle walks from the narrowest distance up, so each one undoes the other for the same control amount. A word-mode flag limits all four operations to the low 32 bits and clears the upper half of the result.

Top module: `bitperm_unit`

## Requirements
- R1: With op_sel = 0 (reverse), result bit i equals data bit (i XOR c), where c is the 6-bit control amount. Stages for distances 1, 2, 4, 8, 16 and 32 are enabled by control bits 0 to 5, so c = 63 reverses the whole word.
- R2: With op_sel = 1 (OR-combine), each enabled stage ORs the swapped word into the current word. Result bit i is then the OR of every data bit j for which (i XOR j) has ones only where c has ones. With c = 7, each byte becomes 0xFF if it was nonzero and 0x00 otherwise.
- R3: With op_sel = 2 (shuffle), control bit k (k = 0..4) enables a stage that exchanges index bits k and k+1 of each bit position. The bits whose two index bits read 01 trade places with the bits whose two index bits read 10, across a distance of 2^k. The enabled stages are applied from k = 4 down to k = 0.
- R4: With op_sel = 3 (unshuffle), the same stages are applied from k = 0 up to k = 4. As a result, unshuffling a shuffled word with the same control amount returns the original word.
- R5: The operation select encoding is 0 for reverse, 1 for OR-combine, 2 for shuffle and 3 for unshuffle.
- R6: Reverse and OR-combine read only control bits 5:0, and shuffle and unshuffle read only control bits 4:0. Higher control bits have no effect on the result.
- R7: When word_mode = 1, data bits 63:32 are treated as zero and result bits 63:32 are zero. Reverse and OR-combine read only control bits 4:0, and shuffle and unshuffle read only control bits 3:0, so no stage moves a bit across the 32-bit boundary.
- R8: A control amount with no enabled stage returns the data operand unchanged (zero-extended from the low half in word mode). All-zero inputs give an all-zero result.
- R9: The unit holds no state. The result depends only on the present inputs and settles within the same cycle in which they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation select: 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle |
| word_mode | input | 1 | 1 limits the operation to the low 32 bits and zeroes the upper half |
| src_data | input | 64 | Data operand to permute |
| src_ctl | input | 64 | Control operand; only its low bits select the stages |
| result | output | 64 | Permuted result |

## Verification
Every result is due in the same cycle as its operands, with no register in the path. The bench therefore applies each stimulus just after a falling clock edge and reads the result one nanosecond later, well before the next rising edge. The round-trip checks send a shuffle result straight back as the data for an unshuffle. Each step follows the same drive-then-sample spacing, so no value is ever read while the path is still settling.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

  localparam int PERM_W = 64;
  localparam int STG_N  = $clog2(PERM_W);

  typedef logic [PERM_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_REV    = 2'd0,
    OP_ORC    = 2'd1,
    OP_SHFL   = 2'd2,
    OP_UNSHFL = 2'd3
  } perm_op_e;

  // Bits whose index has bit k clear: the lower member of each pair at distance 2^k
  function automatic word_t pair_low_mask(input int k);
    word_t m;
    for (int i = 0; i < PERM_W; i++) m[i] = (((i >> k) & 1) == 0);
    return m;
  endfunction

  // Destination of the left-moving bits in interleave stage k: index bits (k+1,k) = 10
  function automatic word_t ilv_left_mask(input int k);
    word_t m;
    for (int i = 0; i < PERM_W; i++)
      m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
    return m;
  endfunction

  // Destination of the right-moving bits in interleave stage k: index bits (k+1,k) = 01
  function automatic word_t ilv_right_mask(input int k);
    word_t m;
    for (int i = 0; i < PERM_W; i++)
      m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    return m;
  endfunction

  // Exchange every pair of 2^k-bit groups
  function automatic word_t rev_step(input word_t x, input int k);
    word_t m;
    m = pair_low_mask(k);
    return ((x & m) << (1 << k)) | ((x & ~m) >> (1 << k));
  endfunction

  // Merge the exchanged word into the current one
  function automatic word_t orc_step(input word_t x, input int k);
    return x | rev_step(x, k);
  endfunction

  // One interleave stage: the middle groups of each 2^(k+2)-bit block trade places
  function automatic word_t ilv_step(input word_t x, input int k);
    word_t ml;
    word_t mr;
    ml = ilv_left_mask(k);
    mr = ilv_right_mask(k);
    return (x & ~(ml | mr)) | ((x << (1 << k)) & ml) | ((x >> (1 << k)) & mr);
  endfunction

endpackage

// File: rtl/bitperm_ctrl.sv
module bitperm_ctrl
  import bitperm_pkg::*;
#(
  parameter int STG = STG_N
) (
  input  perm_op_e         op,
  input  logic             word_mode,
  input  logic [STG-1:0]   ctl_amt,
  output logic [STG-1:0]   bfly_en,
  output logic             bfly_or,
  output logic [STG-2:0]   ilv_en
);

  localparam logic [STG-1:0] BFLY_FULL = '1;
  localparam logic [STG-1:0] BFLY_HALF = BFLY_FULL >> 1;
  localparam logic [STG-2:0] ILV_FULL  = '1;
  localparam logic [STG-2:0] ILV_HALF  = ILV_FULL >> 1;

  logic is_bfly;
  logic is_ilv;
  logic [STG-1:0] bfly_lim;
  logic [STG-2:0] ilv_lim;

  always_comb begin
    is_bfly  = (op == OP_REV) || (op == OP_ORC);
    is_ilv   = (op == OP_SHFL) || (op == OP_UNSHFL);
    bfly_lim = word_mode ? BFLY_HALF : BFLY_FULL;
    ilv_lim  = word_mode ? ILV_HALF : ILV_FULL;
    bfly_en  = is_bfly ? (ctl_amt & bfly_lim) : '0;
    ilv_en   = is_ilv ? (ctl_amt[STG-2:0] & ilv_lim) : '0;
    bfly_or  = (op == OP_ORC);
  end

endmodule

// File: rtl/bitperm_butterfly.sv
module bitperm_butterfly
  import bitperm_pkg::*;
#(
  parameter int W   = PERM_W,
  parameter int STG = STG_N
) (
  input  logic [W-1:0]   din,
  input  logic [STG-1:0] en,
  input  logic           or_mode,
  output logic [W-1:0]   dout
);

  logic [STG:0][W-1:0] tap;

  assign tap[0] = din;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    logic [W-1:0] swapped;
    logic [W-1:0] merged;
    assign swapped    = rev_step(tap[k], k);
    assign merged     = orc_step(tap[k], k);
    assign tap[k + 1] = !en[k] ? tap[k] : (or_mode ? merged : swapped);
  end

  assign dout = tap[STG];

endmodule

// File: rtl/bitperm_interleave.sv
module bitperm_interleave
  import bitperm_pkg::*;
#(
  parameter int W       = PERM_W,
  parameter int STG     = STG_N,
  parameter bit REVERSE = 1'b0
) (
  input  logic [W-1:0]   din,
  input  logic [STG-2:0] en,
  output logic [W-1:0]   dout
);

  localparam int NS = STG - 1;

  logic [NS:0][W-1:0] tap;

  assign tap[0] = din;

  // Forward order walks the widest stage first; reverse order the narrowest first
  for (genvar s = 0; s < NS; s++) begin : g_stage
    localparam int K = REVERSE ? s : (NS - 1 - s);
    logic [W-1:0] moved;
    assign moved      = ilv_step(tap[s], K);
    assign tap[s + 1] = en[K] ? moved : tap[s];
  end

  assign dout = tap[NS];

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int W   = PERM_W,
  parameter int STG = STG_N
) (
  input  logic [1:0]   op_sel,
  input  logic         word_mode,
  input  logic [W-1:0] src_data,
  input  logic [W-1:0] src_ctl,
  output logic [W-1:0] result
);

  localparam int HALF = W / 2;

  perm_op_e         op;
  logic [W-1:0]     data_eff;
  logic [STG-1:0]   ctl_amt;
  logic [STG-1:0]   bfly_en;
  logic             bfly_or;
  logic [STG-2:0]   ilv_en;
  logic [W-1:0]     bfly_res;
  logic [W-1:0]     shfl_res;
  logic [W-1:0]     unshfl_res;

  assign op       = perm_op_e'(op_sel);
  assign data_eff = word_mode ? {{HALF{1'b0}}, src_data[HALF-1:0]} : src_data;
  assign ctl_amt  = src_ctl[STG-1:0];

  bitperm_ctrl #(.STG(STG)) u_ctrl (
    .op        (op),
    .word_mode (word_mode),
    .ctl_amt   (ctl_amt),
    .bfly_en   (bfly_en),
    .bfly_or   (bfly_or),
    .ilv_en    (ilv_en)
  );

  bitperm_butterfly #(.W(W), .STG(STG)) u_bfly (
    .din     (data_eff),
    .en      (bfly_en),
    .or_mode (bfly_or),
    .dout    (bfly_res)
  );

  bitperm_interleave #(.W(W), .STG(STG), .REVERSE(1'b0)) u_shfl (
    .din  (data_eff),
    .en   (ilv_en),
    .dout (shfl_res)
  );

  bitperm_interleave #(.W(W), .STG(STG), .REVERSE(1'b1)) u_unshfl (
    .din  (data_eff),
    .en   (ilv_en),
    .dout (unshfl_res)
  );

  always_comb begin
    unique case (op)
      OP_SHFL:   result = shfl_res;
      OP_UNSHFL: result = unshfl_res;
      default:   result = bfly_res;
    endcase
  end

endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk
  import bitperm_pkg::*;
#(
  parameter int W   = PERM_W,
  parameter int STG = STG_N
) (
  input logic [1:0]     op_sel,
  input logic           word_mode,
  input logic [W-1:0]   src_ctl,
  input logic [W-1:0]   data_eff,
  input logic [STG-1:0] bfly_en,
  input logic [STG-2:0] ilv_en,
  input logic [W-1:0]   result
);

  localparam int HALF = W / 2;

  always_comb begin
    if (!$isunknown({op_sel, word_mode, src_ctl, data_eff, result})) begin
      // R7: word mode never leaves anything in the upper half
      p_word_upper_zero_r7: assert (!word_mode || (result[W-1:HALF] == '0))
        else $error("word mode upper half not zero");
      // R7: word mode keeps the boundary-crossing stages off
      p_word_stage_limit_r7: assert (!word_mode || (!bfly_en[STG-1] && !ilv_en[STG-2]))
        else $error("word mode enabled a full-width stage");
      // R1, R3, R4: pure permutations keep the number of ones
      p_perm_bitcount_r1: assert ((op_sel == 2'd1) ||
                                  ($countones(result) == $countones(data_eff)))
        else $error("permutation changed the ones count");
      // R2: OR-combine never clears an input bit
      p_orc_covers_r2: assert ((op_sel != 2'd1) || ((result & data_eff) == data_eff))
        else $error("OR-combine lost an input bit");
      // R8: no stage enabled means pass-through
      p_idle_pass_r8: assert ((bfly_en != '0) || (ilv_en != '0) || (result == data_eff))
        else $error("idle control altered the data");
      // R6: stage enables come only from the low control bits
      p_ctl_subset_r6: assert (($countones(bfly_en) + $countones(ilv_en)) <= $countones(src_ctl))
        else $error("stage enabled without a control bit");
    end
  end

endmodule

bind bitperm_unit bitperm_unit_chk #(.W(W), .STG(STG)) u_chk (
  .op_sel    (op_sel),
  .word_mode (word_mode),
  .src_ctl   (src_ctl),
  .data_eff  (data_eff),
  .bfly_en   (bfly_en),
  .ilv_en    (ilv_en),
  .result    (result)
);

// File: tb/bitperm_unit_tb.sv
`timescale 1ns/1ps
module bitperm_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic        word_mode = 1'b0;
  logic [63:0] src_data = '0;
  logic [63:0] src_ctl = '0;
  logic [63:0] result;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #5 clk = ~clk;

  bitperm_unit u_dut (
    .op_sel    (op_sel),
    .word_mode (word_mode),
    .src_data  (src_data),
    .src_ctl   (src_ctl),
    .result    (result)
  );

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  // Interleave stage seen as exchanging index bits k and k+1
  function automatic logic [63:0] idx_swap(input logic [63:0] x, input int k);
    logic [63:0] y;
    for (int i = 0; i < 64; i++) begin
      int b0 = (i >> k) & 1;
      int b1 = (i >> (k + 1)) & 1;
      int j  = i & ~((1 << k) | (1 << (k + 1)));
      j = j | (b0 << (k + 1)) | (b1 << k);
      y[i] = x[j];
    end
    return y;
  endfunction

  function automatic logic [63:0] ref_perm(input int op, input bit wm,
                                           input logic [63:0] x, input logic [63:0] c);
    logic [63:0] xs;
    logic [63:0] y;
    int cb;
    int cs;
    xs = wm ? {32'h0, x[31:0]} : x;
    cb = int'(c[5:0]) & (wm ? 31 : 63);
    cs = int'(c[4:0]) & (wm ? 15 : 31);
    y  = xs;
    case (op)
      0: for (int i = 0; i < 64; i++) y[i] = xs[i ^ cb];
      1: for (int i = 0; i < 64; i++) begin
           logic acc = 1'b0;
           for (int j = 0; j < 64; j++)
             if (((i ^ j) & ~cb) == 0) acc = acc | xs[j];
           y[i] = acc;
         end
      2: for (int k = 4; k >= 0; k--) if (cs[k]) y = idx_swap(y, k);
      default: for (int k = 0; k < 5; k++) if (cs[k]) y = idx_swap(y, k);
    endcase
    return y;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive after the falling edge, sample 1 ns later: the path is combinational
  task automatic apply(input int op, input bit wm, input logic [63:0] x, input logic [63:0] c);
    @(negedge clk);
    op_sel    = 2'(op);
    word_mode = wm;
    src_data  = x;
    src_ctl   = c;
    #1;
  endtask

  task automatic t_reset_zero();
    apply(0, 1'b0, '0, '0);
    check("R8 zero inputs", result, 64'h0);
    for (int op = 0; op < 4; op++) begin
      seed = next_rand(seed);
      apply(op, 1'b0, seed, 64'h0);
      check("R8 idle control", result, seed);
    end
  endtask

  task automatic t_rev();
    logic [63:0] exp;
    seed = next_rand(seed);
    apply(0, 1'b0, seed, 64'd63);
    for (int i = 0; i < 64; i++) exp[i] = seed[63 - i];
    check("R1 full reversal", result, exp);
    apply(0, 1'b0, 64'h0123456789ABCDEF, 64'd1);
    check("R1 R5 adjacent bit swap", result, 64'h02138A9B4657CEDF);
    apply(0, 1'b0, 64'h0123456789ABCDEF, 64'd32);
    check("R1 half swap", result, 64'h89ABCDEF01234567);
    for (int n = 0; n < 20; n++) begin
      seed = next_rand(seed);
      apply(0, 1'b0, seed, 64'(n * 3));
      check("R1 reverse pattern", result, ref_perm(0, 1'b0, seed, 64'(n * 3)));
    end
  endtask

  task automatic t_orc();
    logic [63:0] exp;
    apply(1, 1'b0, 64'h0010_0000_8000_0001, 64'd7);
    for (int b = 0; b < 8; b++)
      exp[8*b +: 8] = (64'h0010_0000_8000_0001 >> (8 * b)) & 64'hFF ? 8'hFF : 8'h00;
    check("R2 R5 byte OR-combine", result, exp);
    for (int n = 0; n < 16; n++) begin
      seed = next_rand(seed);
      apply(1, 1'b0, seed & next_rand(seed) & 64'hF0F0_0101_8000_0421, 64'(n * 4 + 1));
      check("R2 OR-combine pattern", result,
            ref_perm(1, 1'b0, seed & next_rand(seed) & 64'hF0F0_0101_8000_0421, 64'(n * 4 + 1)));
    end
  endtask

  task automatic t_shuffle();
    apply(2, 1'b0, 64'h0000_0000_0000_0004, 64'd1);
    check("R3 R5 single-bit shuffle", result, 64'h0000_0000_0000_0002);
    apply(3, 1'b0, 64'h0000_0000_0000_0002, 64'd1);
    check("R4 R5 single-bit unshuffle", result, 64'h0000_0000_0000_0004);
    for (int c = 0; c < 32; c++) begin
      seed = next_rand(seed);
      apply(2, 1'b0, seed, 64'(c));
      check("R3 shuffle pattern", result, ref_perm(2, 1'b0, seed, 64'(c)));
      apply(3, 1'b0, seed, 64'(c));
      check("R4 unshuffle pattern", result, ref_perm(3, 1'b0, seed, 64'(c)));
    end
  endtask

  task automatic t_roundtrip();
    logic [63:0] mid;
    for (int c = 0; c < 32; c++) begin
      seed = next_rand(seed);
      apply(2, 1'b0, seed, 64'(c));
      mid = result;
      apply(3, 1'b0, mid, 64'(c));
      check("R4 round trip", result, seed);
    end
    for (int c = 0; c < 16; c++) begin
      seed = next_rand(seed);
      apply(2, 1'b1, seed, 64'(c));
      mid = result;
      apply(3, 1'b1, mid, 64'(c));
      check("R4 R7 word round trip", result, {32'h0, seed[31:0]});
    end
  endtask

  task automatic t_ctl_high();
    for (int op = 0; op < 4; op++) begin
      seed = next_rand(seed);
      apply(op, 1'b0, seed, {next_rand(seed)} << 6 | 64'd5);
      check("R6 high control ignored", result, ref_perm(op, 1'b0, seed, 64'd5));
    end
    seed = next_rand(seed);
    apply(2, 1'b0, seed, 64'd32);
    check("R6 shuffle bit 5 ignored", result, seed);
    apply(3, 1'b0, seed, 64'd32);
    check("R6 unshuffle bit 5 ignored", result, seed);
  endtask

  task automatic t_word();
    for (int op = 0; op < 4; op++) begin
      for (int n = 0; n < 6; n++) begin
        seed = next_rand(seed);
        apply(op, 1'b1, seed, 64'(n * 11 + 7));
        check("R7 word mode", result, ref_perm(op, 1'b1, seed, 64'(n * 11 + 7)));
      end
    end
    apply(0, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'd63);
    check("R7 word reversal", result, 64'h0000_0000_8000_0000);
    apply(2, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'd16);
    check("R7 word shuffle bit 4 ignored", result, 64'h0000_0000_9ABC_DEF0);
  endtask

  task automatic t_stateless();
    seed = next_rand(seed);
    apply(0, 1'b0, seed, 64'd9);
    check("R9 settle same cycle", result, ref_perm(0, 1'b0, seed, 64'd9));
    @(posedge clk);
    #1;
    check("R9 no state across edge", result, ref_perm(0, 1'b0, seed, 64'd9));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_zero();
    t_rev();
    t_orc();
    t_shuffle();
    t_roundtrip();
    t_ctl_high();
    t_word();
    t_stateless();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule